// File: doc/BRIEF.md
# Checkpoint Commit Controller

This block takes the place of a per-instruction reorder buffer. It keeps a small circular table of checkpoints. Each checkpoint stands for an interval of consecutive decoded instructions and holds a counter of how many of those instructions have not yet finished. Every decoded instruction is tagged with the checkpoint it belongs to. It carries that tag through execution and hands it back on the completion port when it finishes, in any order.

New checkpoints are opened at decode according to a threshold policy:
- when the table is empty;
- at a branch once the current interval is long enough;
- at any instruction once the interval reaches a hard length limit;
- once the interval has collected its allowed number of stores.

The oldest checkpoint retires, raising a one-cycle commit strobe with its index, as soon as its counter is zero and a younger checkpoint has closed its interval. Downstream logic uses that strobe to release the interval's buffered stores and the registers marked for freeing. A rollback request names the surviving checkpoint and throws away every younger one. A flush empties the table.

Top module: `ckpt_commit_unit`

## Requirements
- R1: After reset the table is empty, `decReady` is 1 and `commitValid` is 0. Whenever the table is empty, the next decoded instruction opens a checkpoint at the current tail index and carries that index. The table never becomes empty again except by a flush.
- R2: Once the current interval holds at least `BR_LIMIT` instructions, a decoded branch opens a new checkpoint and belongs to it. A branch arriving earlier stays in the current interval.
- R3: Once the current interval holds `ANY_LIMIT` instructions, the next decoded instruction of any kind opens a new checkpoint.
- R4: Once the current interval holds `ST_LIMIT` stores (`decStore`=1), the next decoded instruction opens a new checkpoint.
- R5: An instruction that opens no checkpoint is tagged with the youngest checkpoint. Acceptance adds one to the tagged counter, and `cmpValid` subtracts one from the counter at `cmpTag`. Both on the same entry in one cycle leave it unchanged.
- R6: `commitValid` is 1 exactly when the oldest checkpoint's counter is zero and at least two checkpoints exist. `commitTag` is then the oldest index. At most one checkpoint commits per cycle, always the oldest.
- R7: `rbValid` keeps the checkpoints from the oldest up to `rbTag` and discards the younger ones. The survivor becomes the youngest with a zero counter, and the interval's instruction and store counts restart from zero. In that cycle decode is refused, completion is ignored and nothing commits.
- R8: `flushAll` empties the table, with the head moving to the tail, and clears every counter. In that cycle decode is refused, completion is ignored and nothing commits. It takes priority over rollback.
- R9: `decReady` is 0 when an instruction would open a checkpoint while all `DEPTH` entries are occupied. It is 1 otherwise, when neither rollback nor flush is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | A decoded instruction is presented |
| decBranch | input | 1 | The presented instruction is a branch |
| decStore | input | 1 | The presented instruction is a store |
| decReady | output | 1 | The presented instruction is accepted this cycle |
| decTag | output | IDX_W | Checkpoint index the presented instruction belongs to |
| cmpValid | input | 1 | An instruction finished execution |
| cmpTag | input | IDX_W | Checkpoint index carried by the finished instruction |
| rbValid | input | 1 | Misspeculation rollback request |
| rbTag | input | IDX_W | Checkpoint that survives the rollback |
| flushAll | input | 1 | Full pipeline flush, empties the table |
| commitValid | output | 1 | Oldest checkpoint commits this cycle |
| commitTag | output | IDX_W | Index of the committing checkpoint |

## Verification
The hardest states to reach from the ports are a full table that stalls decode and an interval that hits its hard length limit without a single branch. A full table needs many checkpoints open at once while completions lag behind. The branch-free limit needs long runs with no branch at all. The bench runs a reduced configuration (four entries, thresholds 4/8/3) through phases with different mixes of branches, stores, completion rate and rollback rate. A starved-completion phase fills the table, and a branch-free, store-free phase reaches the hard limit. A behavioural model written from the requirements predicts every tag, stall and commit cycle by cycle, and the bench confirms at the end that each placement rule, the stall and the rollback were actually exercised.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  // Strobes from control to the counter table
  typedef struct packed {
    logic incEn;     // accepted decode adds to incIdx
    logic decEn;     // completion subtracts from cmpIdx
    logic rbClr;     // rollback clears survivor and younger entries
    logic flushClr;  // flush clears every entry
  } ctrlStrobe_t;

  // Distance of slot p from head h in a ring of the given depth
  function automatic int ringDist(input int p, input int h, input int depth);
    return (p >= h) ? (p - h) : (p + depth - h);
  endfunction

endpackage

// File: rtl/ckpt_counters.sv
module ckpt_counters
  import ckpt_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ANY_LIMIT = 512,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(ANY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [IDX_W-1:0] incIdx,
  input  logic [IDX_W-1:0] cmpIdx,
  input  logic [IDX_W-1:0] rbIdx,
  input  logic [IDX_W-1:0] headIdx,
  output logic [DEPTH-1:0] zeroVec
);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_entry
      logic [CNT_W-1:0] cntQ;
      logic incHit, decHit, clrHit;

      always_comb begin
        incHit = strobe.incEn && (incIdx == IDX_W'(gi));
        decHit = strobe.decEn && (cmpIdx == IDX_W'(gi));
        clrHit = strobe.flushClr ||
                 (strobe.rbClr &&
                  (ringDist(gi, int'(headIdx), DEPTH) >= ringDist(int'(rbIdx), int'(headIdx), DEPTH)));
      end

      always_ff @(posedge clk) begin
        if (!rstN)       cntQ <= '0;
        else if (clrHit) cntQ <= '0;
        else             cntQ <= cntQ + CNT_W'(incHit) - CNT_W'(decHit);
      end

      assign zeroVec[gi] = (cntQ == '0);

      // R5
      underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
        (decHit && !incHit && !clrHit) |-> (cntQ != '0));
    end
  endgenerate

  // R7
  rb_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rbClr && !strobe.flushClr) |=> zeroVec[$past(rbIdx)]);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushClr |=> (&zeroVec));

endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int BR_LIMIT  = 64,
  parameter int ANY_LIMIT = 512,
  parameter int ST_LIMIT  = 64,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int INST_W   = $clog2(ANY_LIMIT + 1),
  localparam int ST_W     = $clog2(ST_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic             decBranch,
  input  logic             decStore,
  output logic             decReady,
  output logic [IDX_W-1:0] decTag,
  input  logic             cmpValid,
  input  logic             rbValid,
  input  logic [IDX_W-1:0] rbTag,
  input  logic             flushAll,
  input  logic [DEPTH-1:0] zeroVec,
  output logic             commitValid,
  output logic [IDX_W-1:0] commitTag,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] headIdx
);

  logic [IDX_W-1:0]  headQ, tailQ;
  logic [OCC_W-1:0]  occQ;
  logic [INST_W-1:0] instQ;
  logic [ST_W-1:0]   storeQ;

  logic needNew, tableFull, decFire, openFire;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] backIdx(input logic [IDX_W-1:0] p);
    return (p == '0) ? IDX_W'(DEPTH - 1) : p - IDX_W'(1);
  endfunction

  always_comb begin
    needNew   = (occQ == '0) ||
                (decBranch && (instQ >= INST_W'(BR_LIMIT))) ||
                (instQ >= INST_W'(ANY_LIMIT)) ||
                (storeQ >= ST_W'(ST_LIMIT));
    tableFull = (occQ == OCC_W'(DEPTH));
    decReady  = !rbValid && !flushAll && !(needNew && tableFull);
    decTag    = needNew ? tailQ : backIdx(tailQ);
    decFire   = decValid && decReady;
    openFire  = decFire && needNew;

    commitValid = !rbValid && !flushAll && (occQ >= OCC_W'(2)) && zeroVec[headQ];
    commitTag   = headQ;
    headIdx     = headQ;

    strobe.incEn    = decFire;
    strobe.decEn    = cmpValid && !rbValid && !flushAll;
    strobe.rbClr    = rbValid && !flushAll;
    strobe.flushClr = flushAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      occQ   <= '0;
      instQ  <= '0;
      storeQ <= '0;
    end else if (flushAll) begin
      headQ  <= tailQ;
      occQ   <= '0;
      instQ  <= '0;
      storeQ <= '0;
    end else if (rbValid) begin
      occQ   <= OCC_W'(ringDist(int'(rbTag), int'(headQ), DEPTH) + 1);
      tailQ  <= stepIdx(rbTag);
      instQ  <= '0;
      storeQ <= '0;
    end else begin
      if (commitValid) headQ <= stepIdx(headQ);
      if (openFire)    tailQ <= stepIdx(tailQ);
      occQ <= occQ + OCC_W'(openFire) - OCC_W'(commitValid);
      if (decFire) begin
        if (needNew) begin
          instQ  <= INST_W'(1);
          storeQ <= ST_W'(decStore);
        end else begin
          instQ  <= instQ + INST_W'(1);
          storeQ <= storeQ + ST_W'(decStore);
        end
      end
    end
  end

  // R1
  keep_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((occQ != '0) && !flushAll) |=> (occQ != '0));

  // R9
  stall_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decReady && !rbValid && !flushAll) |-> (occQ == OCC_W'(DEPTH)));

  // R6
  commit_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> (occQ <= $past(occQ)));

endmodule

// File: rtl/ckpt_commit_unit.sv
module ckpt_commit_unit
  import ckpt_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int BR_LIMIT  = 64,
  parameter int ANY_LIMIT = 512,
  parameter int ST_LIMIT  = 64,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic             decBranch,
  input  logic             decStore,
  output logic             decReady,
  output logic [IDX_W-1:0] decTag,
  input  logic             cmpValid,
  input  logic [IDX_W-1:0] cmpTag,
  input  logic             rbValid,
  input  logic [IDX_W-1:0] rbTag,
  input  logic             flushAll,
  output logic             commitValid,
  output logic [IDX_W-1:0] commitTag
);

  ctrlStrobe_t      strobe;
  logic [DEPTH-1:0] zeroVec;
  logic [IDX_W-1:0] headIdx;

  ckpt_ctrl #(
    .DEPTH(DEPTH), .BR_LIMIT(BR_LIMIT), .ANY_LIMIT(ANY_LIMIT), .ST_LIMIT(ST_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decBranch(decBranch), .decStore(decStore),
    .decReady(decReady), .decTag(decTag),
    .cmpValid(cmpValid), .rbValid(rbValid), .rbTag(rbTag), .flushAll(flushAll),
    .zeroVec(zeroVec), .commitValid(commitValid), .commitTag(commitTag),
    .strobe(strobe), .headIdx(headIdx)
  );

  ckpt_counters #(
    .DEPTH(DEPTH), .ANY_LIMIT(ANY_LIMIT)
  ) i_counters (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .incIdx(decTag), .cmpIdx(cmpTag), .rbIdx(rbTag), .headIdx(headIdx),
    .zeroVec(zeroVec)
  );

endmodule

// File: tb/test_ckpt_commit_unit.sv
module test_ckpt_commit_unit;
  localparam int D = 4, BRL = 4, ANYL = 8, STL = 3, IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic decValid = 1'b0, decBranch = 1'b0, decStore = 1'b0;
  logic decReady, commitValid;
  logic [IW-1:0] decTag, commitTag;
  logic cmpValid = 1'b0, rbValid = 1'b0, flushAll = 1'b0;
  logic [IW-1:0] cmpTag = '0, rbTag = '0;

  ckpt_commit_unit #(.DEPTH(D), .BR_LIMIT(BRL), .ANY_LIMIT(ANYL), .ST_LIMIT(STL)) i_ckpt_commit_unit (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decBranch(decBranch), .decStore(decStore),
    .decReady(decReady), .decTag(decTag), .cmpValid(cmpValid), .cmpTag(cmpTag),
    .rbValid(rbValid), .rbTag(rbTag), .flushAll(flushAll),
    .commitValid(commitValid), .commitTag(commitTag));

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  int mHead = 0, mTail = 0, mOcc = 0, mInst = 0, mStore = 0;
  int mCnt[D];
  int hitEmpty = 0, hitBr = 0, hitAny = 0, hitSt = 0, hitStall = 0, hitRb = 0, hitFl = 0, hitCommit = 0, hitNet = 0;
  bit prevRb = 1'b0, prevFl = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(input int pDec, input int pBr, input int pSt, input int pCmp, input int pRb, input int pFl);
    bit nn, full, expReady, expCommit;
    int expTag, cand, d;
    string why;
    @(negedge clk);
    decValid  = ($urandom_range(99) < pDec);
    decBranch = ($urandom_range(99) < pBr);
    decStore  = ($urandom_range(99) < pSt);
    flushAll  = ($urandom_range(999) < pFl);
    rbValid   = 1'b0;
    if (mOcc > 0 && $urandom_range(999) < pRb) begin
      rbValid = 1'b1;
      rbTag = IW'((mHead + int'($urandom_range(mOcc - 1))) % D);
    end
    cmpValid = 1'b0;
    if ($urandom_range(99) < pCmp) begin
      cand = int'($urandom_range(D - 1));
      for (int k = 0; k < D; k++)
        if (!cmpValid && mCnt[(cand + k) % D] > 0) begin
          cmpValid = 1'b1;
          cmpTag = IW'((cand + k) % D);
        end
    end
    #1;
    nn = (mOcc == 0) || (decBranch && mInst >= BRL) || (mInst >= ANYL) || (mStore >= STL);
    full = (mOcc == D);
    expReady = !rbValid && !flushAll && !(nn && full);
    expTag = nn ? mTail : (mTail + D - 1) % D;
    expCommit = !rbValid && !flushAll && mOcc >= 2 && mCnt[mHead] == 0;
    if (nn && full && !rbValid && !flushAll) begin hitStall++; why = "R9 stall on full table"; end
    else if (flushAll) why = "R8 decode refused during flush";
    else if (rbValid) why = "R7 decode refused during rollback";
    else why = "R9 ready";
    chk(decReady == expReady, why, int'(decReady), int'(expReady));
    if (decValid && expReady) begin
      if (prevFl) why = "R8 tag after flush";
      else if (prevRb) why = "R7 tag after rollback";
      else if (mOcc == 0) begin hitEmpty++; why = "R1 open on empty table"; end
      else if (decBranch && mInst >= BRL) begin hitBr++; why = "R2 branch threshold"; end
      else if (mInst >= ANYL) begin hitAny++; why = "R3 length threshold"; end
      else if (mStore >= STL) begin hitSt++; why = "R4 store threshold"; end
      else why = "R5 youngest tag";
      chk(int'(decTag) == expTag, why, int'(decTag), expTag);
      if (!nn && cmpValid && int'(cmpTag) == expTag) hitNet++;
    end
    chk(commitValid == expCommit, "R6 commit strobe", int'(commitValid), int'(expCommit));
    if (expCommit) begin
      hitCommit++;
      chk(int'(commitTag) == mHead, "R6 commit order", int'(commitTag), mHead);
    end
    prevRb = rbValid && !flushAll;
    prevFl = flushAll;
    if (flushAll) begin
      hitFl++;
      mHead = mTail; mOcc = 0; mInst = 0; mStore = 0;
      for (int k = 0; k < D; k++) mCnt[k] = 0;
    end else if (rbValid) begin
      hitRb++;
      d = (int'(rbTag) - mHead + D) % D;
      for (int k = 0; k < D; k++) if (((k - mHead + D) % D) >= d) mCnt[k] = 0;
      mOcc = d + 1; mTail = (int'(rbTag) + 1) % D; mInst = 0; mStore = 0;
    end else begin
      if (expCommit) begin mHead = (mHead + 1) % D; mOcc--; end
      if (decValid && expReady) begin
        if (nn) begin mTail = (mTail + 1) % D; mOcc++; mInst = 1; mStore = int'(decStore); end
        else begin mInst++; mStore += int'(decStore); end
        mCnt[expTag]++;
      end
      if (cmpValid) mCnt[int'(cmpTag)]--;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < D; k++) mCnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(decReady == 1'b1, "R1 reset ready", int'(decReady), 1);
    chk(commitValid == 1'b0, "R1 reset no commit", int'(commitValid), 0);
    chk(decTag == '0, "R1 reset tail", int'(decTag), 0);
    for (int i = 0; i < 3000; i++) cycle(70, 15, 20, 55, 15, 3);
    for (int i = 0; i < 2000; i++) cycle(80, 0, 0, 60, 5, 0);
    for (int i = 0; i < 2000; i++) cycle(70, 5, 70, 50, 5, 1);
    for (int i = 0; i < 2000; i++) cycle(90, 30, 10, 15, 10, 1);
    @(negedge clk);
    decValid = 1'b0; cmpValid = 1'b0; rbValid = 1'b0; flushAll = 1'b0;
    chk(hitEmpty > 0, "R1 coverage", hitEmpty, 1);
    chk(hitBr > 0, "R2 coverage", hitBr, 1);
    chk(hitAny > 0, "R3 coverage", hitAny, 1);
    chk(hitSt > 0, "R4 coverage", hitSt, 1);
    chk(hitNet > 0, "R5 same-cycle net coverage", hitNet, 1);
    chk(hitCommit > 0, "R6 coverage", hitCommit, 1);
    chk(hitRb > 0, "R7 coverage", hitRb, 1);
    chk(hitFl > 0, "R8 coverage", hitFl, 1);
    chk(hitStall > 0, "R9 coverage", hitStall, 1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule